// File: doc/BRIEF.md
# Receive Frame Sorter and Splitter

This block sits on the receive side of a token-ring MAC. It accepts a received frame as a byte stream, one byte per accepted cycle, with a start marker on the frame-control (FC) byte and an end marker on the last byte. It decides on the FC byte which of three indicate channels the frame belongs to and forwards each byte one cycle later, tagged with its channel and with per-channel start and end markers. Upstream address recognition is reduced to two match flags that are presented with the FC byte.

Two sort modes exist. In address-sort mode the match flags and the frame type pick one channel for the whole frame. In header-split mode an accepted data frame is cut in two: its first bytes, up to a programmable header length, go to channel 1, and the rest go to channel 2. MAC and SMT frames are never cut. Void frames never reach the output. A MAC frame that repeats the FC and information field of the last forwarded MAC frame can optionally be cancelled. That condition is only known at the last byte, so such a frame is flagged with an abort marker on its final output byte and downstream storage drops it.

Top module: `rx_frame_sorter`

## Requirements
- R1: After reset, and in every cycle that follows a cycle without an accepted input byte, out_valid, out_sof, out_eof and out_abort are low.
- R2: The FC byte is read as bit 7 class, bit 6 address length (1 = 6-byte addresses, 0 = 2-byte), bits 5:4 format, bits 3:0 control. Format 00 with control 0000 is void. Format 00 with nonzero control is an SMT frame when the class is 0 and a MAC frame when the class is 1. Any other format is a data frame.
- R3: A void frame produces no output byte.
- R4: In header-split mode (cfg_split_mode = 1), an accepted data frame sends byte index i (FC = index 0) to channel 1 when i < cfg_hdr_len and to channel 2 otherwise. out_chan encodes channel n as the value n.
- R5: In header-split mode an accepted MAC or SMT frame goes whole to channel 0.
- R6: In address-sort mode (cfg_split_mode = 0), a frame with in_match_ext set goes to channel 2, whatever in_match_int says.
- R7: In address-sort mode, a frame with only in_match_int set goes to channel 0 when it is MAC or SMT and to channel 1 otherwise.
- R8: A frame counts as accepted when in_match_int, in_match_ext or cfg_promisc is set. A frame that is not accepted produces no output. In address-sort mode a frame accepted only through cfg_promisc is routed as if in_match_int were set.
- R9: Each forwarded byte appears on out_data exactly one cycle after it is accepted. out_sof marks the first byte and out_eof marks the last byte that a frame places on each channel.
- R10: With cfg_dup_en set, a MAC frame is a duplicate when its FC byte and its information bytes equal those of the last forwarded, non-duplicate MAC frame. The information bytes are the bytes after the destination and source address fields. A duplicate carries out_abort on its final output byte, together with out_eof, and does not replace the remembered frame. Frames that are dropped are never remembered.
- R11: out_abort stays low for non-MAC frames and for every frame that starts while cfg_dup_en is clear.
- R12: The configuration inputs and the match flags are taken only with the start byte. Changes later in the frame do not alter its routing. Bytes with in_valid high that arrive outside a frame produce no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_split_mode | input | 1 | 1 = header-split mode, 0 = address-sort mode |
| cfg_hdr_len | input | HLEN_W | Header length in bytes for header-split mode |
| cfg_dup_en | input | 1 | Enable cancelling of repeated MAC frames |
| cfg_promisc | input | 1 | Accept frames that match no address |
| in_valid | input | 1 | Input byte valid |
| in_sof | input | 1 | Input byte is the FC byte of a new frame |
| in_eof | input | 1 | Input byte is the last byte of the frame |
| in_data | input | 8 | Input byte |
| in_match_int | input | 1 | Frame matches the internal address (valid with in_sof) |
| in_match_ext | input | 1 | Frame matches the external address (valid with in_sof) |
| out_valid | output | 1 | Output byte valid |
| out_chan | output | 2 | Indicate channel of the output byte (0, 1 or 2) |
| out_sof | output | 1 | First byte of this frame on this channel |
| out_eof | output | 1 | Last byte of this frame on this channel |
| out_abort | output | 1 | Frame is a duplicate; cancel it (only with out_eof) |
| out_data | output | 8 | Output byte |

## Verification
The cycle-level assertions check properties that hold for every byte. Output data follows the input by exactly one cycle. An abort marker never appears without an end marker. The channel code is always legal. A void start byte is never forwarded. Which channel a given frame type, match pattern and header length selects, where the split falls, and whether a repeated MAC frame is cancelled all depend on history and configuration. Only the bench's sweeps and directed duplicate sequences, compared against an independently computed route and byte-by-byte key, can show those.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

    typedef enum logic [1:0] {
        FT_VOID = 2'd0,
        FT_SMT  = 2'd1,
        FT_MAC  = 2'd2,
        FT_USER = 2'd3
    } ftype_e;

    typedef enum logic [2:0] {
        RT_DROP  = 3'd0,
        RT_CH0   = 3'd1,
        RT_CH1   = 3'd2,
        RT_CH2   = 3'd3,
        RT_SPLIT = 3'd4
    } route_e;

    localparam logic [1:0] CHAN0 = 2'd0;
    localparam logic [1:0] CHAN1 = 2'd1;
    localparam logic [1:0] CHAN2 = 2'd2;

    localparam int SHORT_ADDR_BYTES = 2;
    localparam int LONG_ADDR_BYTES  = 6;

endpackage

// File: rtl/rfs_fc_decode.sv
module rfs_fc_decode
    import rfs_pkg::*;
(
    input  logic [7:0] fc,
    output ftype_e     ftype,
    output logic       long_addr
);
    logic       cls;
    logic [1:0] fmt;
    logic [3:0] ctl;

    always_comb begin
        cls       = fc[7];
        long_addr = fc[6];
        fmt       = fc[5:4];
        ctl       = fc[3:0];
        if (fmt != 2'b00) begin
            ftype = FT_USER;
        end else if (ctl == 4'd0) begin
            ftype = FT_VOID;
        end else if (cls) begin
            ftype = FT_MAC;
        end else begin
            ftype = FT_SMT;
        end
    end
endmodule

// File: rtl/rfs_route_sel.sv
module rfs_route_sel
    import rfs_pkg::*;
(
    input  ftype_e ftype,
    input  logic   split_mode,
    input  logic   match_int,
    input  logic   match_ext,
    input  logic   promisc,
    output route_e route
);
    logic accepted;
    logic mgmt;

    always_comb begin
        accepted = match_int | match_ext | promisc;
        mgmt     = (ftype == FT_MAC) || (ftype == FT_SMT);
        route    = RT_DROP;
        if (ftype == FT_VOID) begin
            route = RT_DROP;
        end else if (split_mode) begin
            if (!accepted)  route = RT_DROP;
            else if (mgmt)  route = RT_CH0;
            else            route = RT_SPLIT;
        end else begin
            if (match_ext)                  route = RT_CH2;
            else if (match_int || promisc)  route = mgmt ? RT_CH0 : RT_CH1;
            else                            route = RT_DROP;
        end
    end
endmodule

// File: rtl/rfs_sig_step.sv
module rfs_sig_step #(
    parameter int               SIG_W = 16,
    parameter logic [SIG_W-1:0] POLY  = 16'h1021
) (
    input  logic [SIG_W-1:0] sig_in,
    input  logic [7:0]       byte_in,
    output logic [SIG_W-1:0] sig_out
);
    logic [SIG_W-1:0] acc;
    logic             fb;

    always_comb begin
        acc = sig_in;
        fb  = 1'b0;
        for (int b = 7; b >= 0; b--) begin
            fb  = acc[SIG_W-1] ^ byte_in[b];
            acc = {acc[SIG_W-2:0], 1'b0};
            if (fb) acc = acc ^ POLY;
        end
        sig_out = acc;
    end
endmodule

// File: rtl/rfs_dup_track.sv
module rfs_dup_track #(
    parameter int SIG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             store,
    input  logic [SIG_W-1:0] sig_new,
    output logic             last_valid,
    output logic [SIG_W-1:0] last_sig
);
    typedef struct packed {
        logic             vld;
        logic [SIG_W-1:0] sig;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d = trk_q;
        if (store) begin
            trk_d.vld = 1'b1;
            trk_d.sig = sig_new;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    assign last_valid = trk_q.vld;
    assign last_sig   = trk_q.sig;
endmodule

// File: rtl/rx_frame_sorter.sv
module rx_frame_sorter
    import rfs_pkg::*;
#(
    parameter int               HLEN_W   = 6,
    parameter int               CNT_W    = 12,
    parameter int               SIG_W    = 16,
    parameter logic [SIG_W-1:0] SIG_POLY = 16'h1021
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_split_mode,
    input  logic [HLEN_W-1:0] cfg_hdr_len,
    input  logic              cfg_dup_en,
    input  logic              cfg_promisc,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic              in_eof,
    input  logic [7:0]        in_data,
    input  logic              in_match_int,
    input  logic              in_match_ext,
    output logic              out_valid,
    output logic [1:0]        out_chan,
    output logic              out_sof,
    output logic              out_eof,
    output logic              out_abort,
    output logic [7:0]        out_data
);
    localparam logic [CNT_W-1:0] IDX_MAX    = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] SPAN_SHORT = CNT_W'(2 * SHORT_ADDR_BYTES);
    localparam logic [CNT_W-1:0] SPAN_LONG  = CNT_W'(2 * LONG_ADDR_BYTES);
    localparam logic [SIG_W-1:0] SIG_INIT   = {SIG_W{1'b1}};

    typedef struct packed {
        logic              in_frame;
        logic [CNT_W-1:0]  idx;
        route_e            route;
        logic [HLEN_W-1:0] hdr;
        logic              is_mac;
        logic              long_addr;
        logic              dup_en;
        logic [SIG_W-1:0]  sig;
        logic              o_valid;
        logic [1:0]        o_chan;
        logic              o_sof;
        logic              o_eof;
        logic              o_abort;
        logic [7:0]        o_data;
    } st_t;

    st_t st_d, st_q;

    // decode of the incoming byte as an FC byte
    ftype_e fresh_type;
    logic   fresh_long;
    route_e fresh_route;

    rfs_fc_decode u_dec (
        .fc        (in_data),
        .ftype     (fresh_type),
        .long_addr (fresh_long)
    );

    rfs_route_sel u_route (
        .ftype      (fresh_type),
        .split_mode (cfg_split_mode),
        .match_int  (in_match_int),
        .match_ext  (in_match_ext),
        .promisc    (cfg_promisc),
        .route      (fresh_route)
    );

    // per-byte view of the frame in progress
    logic              first;
    logic              active;
    logic [CNT_W-1:0]  cur_idx;
    route_e            cur_route;
    logic [HLEN_W-1:0] cur_hdr;
    logic              cur_mac;
    logic              cur_long;
    logic              cur_dup_en;
    logic [CNT_W-1:0]  hdr_ext;
    logic [CNT_W-1:0]  addr_span;
    logic              in_hdr;
    logic              sig_take;
    logic [SIG_W-1:0]  sig_base;
    logic [SIG_W-1:0]  sig_stepped;
    logic [SIG_W-1:0]  sig_next;
    logic              last_valid;
    logic [SIG_W-1:0]  last_sig;
    logic              dup_hit;
    logic              mac_store;

    always_comb begin
        first      = in_valid && in_sof;
        active     = in_valid && (in_sof || st_q.in_frame);
        cur_idx    = first ? '0              : st_q.idx;
        cur_route  = first ? fresh_route     : st_q.route;
        cur_hdr    = first ? cfg_hdr_len     : st_q.hdr;
        cur_mac    = first ? (fresh_type == FT_MAC) : st_q.is_mac;
        cur_long   = first ? fresh_long      : st_q.long_addr;
        cur_dup_en = first ? cfg_dup_en      : st_q.dup_en;
        hdr_ext    = CNT_W'(cur_hdr);
        addr_span  = cur_long ? SPAN_LONG : SPAN_SHORT;
        in_hdr     = cur_idx < hdr_ext;
        sig_base   = first ? SIG_INIT : st_q.sig;
        sig_take   = (cur_idx == '0) || (cur_idx > addr_span);
        sig_next   = sig_take ? sig_stepped : sig_base;
    end

    rfs_sig_step #(
        .SIG_W (SIG_W),
        .POLY  (SIG_POLY)
    ) u_sig (
        .sig_in  (sig_base),
        .byte_in (in_data),
        .sig_out (sig_stepped)
    );

    always_comb begin
        dup_hit = active && in_eof && cur_mac && cur_dup_en && last_valid
                  && (sig_next == last_sig) && (cur_route != RT_DROP);
        mac_store = active && in_eof && cur_mac && (cur_route != RT_DROP) && !dup_hit;
    end

    rfs_dup_track #(
        .SIG_W (SIG_W)
    ) u_dup (
        .clk        (clk),
        .rst_n      (rst_n),
        .store      (mac_store),
        .sig_new    (sig_next),
        .last_valid (last_valid),
        .last_sig   (last_sig)
    );

    // next-state and output computation
    always_comb begin
        st_d         = st_q;
        st_d.o_valid = 1'b0;
        st_d.o_sof   = 1'b0;
        st_d.o_eof   = 1'b0;
        st_d.o_abort = 1'b0;
        if (active) begin
            st_d.in_frame  = !in_eof;
            st_d.idx       = (cur_idx == IDX_MAX) ? cur_idx : cur_idx + CNT_W'(1);
            st_d.route     = cur_route;
            st_d.hdr       = cur_hdr;
            st_d.is_mac    = cur_mac;
            st_d.long_addr = cur_long;
            st_d.dup_en    = cur_dup_en;
            st_d.sig       = sig_next;
            st_d.o_data    = in_data;
            case (cur_route)
                RT_CH0, RT_CH1, RT_CH2: begin
                    st_d.o_valid = 1'b1;
                    st_d.o_chan  = (cur_route == RT_CH0) ? CHAN0 :
                                   (cur_route == RT_CH1) ? CHAN1 : CHAN2;
                    st_d.o_sof   = (cur_idx == '0);
                    st_d.o_eof   = in_eof;
                    st_d.o_abort = dup_hit;
                end
                RT_SPLIT: begin
                    st_d.o_valid = 1'b1;
                    st_d.o_chan  = in_hdr ? CHAN1 : CHAN2;
                    st_d.o_sof   = in_hdr ? (cur_idx == '0) : (cur_idx == hdr_ext);
                    st_d.o_eof   = in_eof || (in_hdr && (cur_idx + CNT_W'(1) == hdr_ext));
                    st_d.o_abort = 1'b0;
                end
                default: begin
                    st_d.o_valid = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.o_valid;
    assign out_chan  = st_q.o_chan;
    assign out_sof   = st_q.o_sof;
    assign out_eof   = st_q.o_eof;
    assign out_abort = st_q.o_abort;
    assign out_data  = st_q.o_data;
endmodule

// File: rtl/rx_frame_sorter_chk.sv
module rx_frame_sorter_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       in_sof,
    input logic [7:0] in_data,
    input logic       out_valid,
    input logic [1:0] out_chan,
    input logic       out_sof,
    input logic       out_eof,
    input logic       out_abort,
    input logic [7:0] out_data
);
    assert_abort_with_eof_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_abort) |-> out_eof);

    assert_chan_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_chan != 2'd3));

    assert_void_dropped_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sof && (in_data[5:0] == 6'd0)) |=> !out_valid);

    assert_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($past(in_valid) && (out_data == $past(in_data))));

    assert_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(in_valid) |-> (!out_valid && !out_sof && !out_eof && !out_abort));
endmodule

bind rx_frame_sorter rx_frame_sorter_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_sof    (in_sof),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_chan  (out_chan),
    .out_sof   (out_sof),
    .out_eof   (out_eof),
    .out_abort (out_abort),
    .out_data  (out_data)
);

// File: tb/rx_frame_sorter_tb.sv
module rx_frame_sorter_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HLEN_W     = 6;
    localparam int WATCHDOG   = 150000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_split_mode = 1'b0;
    logic [HLEN_W-1:0] cfg_hdr_len = '0;
    logic              cfg_dup_en = 1'b0;
    logic              cfg_promisc = 1'b0;
    logic              in_valid = 1'b0;
    logic              in_sof = 1'b0;
    logic              in_eof = 1'b0;
    logic [7:0]        in_data = 8'h00;
    logic              in_match_int = 1'b0;
    logic              in_match_ext = 1'b0;
    logic              out_valid;
    logic [1:0]        out_chan;
    logic              out_sof;
    logic              out_eof;
    logic              out_abort;
    logic [7:0]        out_data;

    int   n_total = 0;
    int   n_fail  = 0;
    bit   done    = 1'b0;

    logic [7:0] fbuf [0:31];
    int         flen;
    logic [7:0] last_key [0:31];
    int         last_klen = 0;
    bit         last_ok   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_frame_sorter #(.HLEN_W(HLEN_W)) u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_split_mode (cfg_split_mode),
        .cfg_hdr_len    (cfg_hdr_len),
        .cfg_dup_en     (cfg_dup_en),
        .cfg_promisc    (cfg_promisc),
        .in_valid       (in_valid),
        .in_sof         (in_sof),
        .in_eof         (in_eof),
        .in_data        (in_data),
        .in_match_int   (in_match_int),
        .in_match_ext   (in_match_ext),
        .out_valid      (out_valid),
        .out_chan       (out_chan),
        .out_sof        (out_sof),
        .out_eof        (out_eof),
        .out_abort      (out_abort),
        .out_data       (out_data)
    );

    task automatic summary();
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_total++;
            n_fail++;
            $display("FAIL watchdog: run did not finish (got hang, expected completion)");
            summary();
            $finish;
        end
    end

    task automatic drive_byte(input logic v, input logic s, input logic e, input logic [7:0] d);
        @(negedge clk);
        in_valid = v;
        in_sof   = s;
        in_eof   = e;
        in_data  = d;
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input logic ev, input logic [1:0] ec,
                         input logic es, input logic ee, input logic ea, input logic [7:0] ed);
        bit ok;
        n_total++;
        ok = (out_valid == ev) &&
             (!ev || (out_chan == ec && out_sof == es && out_eof == ee &&
                      out_abort == ea && out_data == ed));
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got v=%b ch=%0d sof=%b eof=%b abort=%b d=%h, expected v=%b ch=%0d sof=%b eof=%b abort=%b d=%h",
                     tag, out_valid, out_chan, out_sof, out_eof, out_abort, out_data,
                     ev, ec, es, ee, ea, ed);
        end
    endtask

    // Expected route from R2..R8: -1 none, 0..2 channel, 3 header split
    function automatic int exp_route(input logic [7:0] fc, input logic split,
                                     input logic mi, input logic me, input logic pr);
        bit is_void, mgmt;
        is_void = (fc[5:4] == 2'b00) && (fc[3:0] == 4'd0);
        mgmt    = (fc[5:4] == 2'b00) && (fc[3:0] != 4'd0);
        if (is_void) return -1;
        if (split) begin
            if (!(mi || me || pr)) return -1;
            return mgmt ? 0 : 3;
        end
        if (me) return 2;
        if (mi || pr) return mgmt ? 0 : 1;
        return -1;
    endfunction

    task automatic run_frame(input string ctx, input bit scramble);
        logic              m, mi, me, pr, de;
        logic [HLEN_W-1:0] h;
        logic [7:0]        fc;
        logic [7:0]        key [0:31];
        int                klen, span, r, hl;
        bit                mac, dup;
        string             tag;
        m  = cfg_split_mode; h = cfg_hdr_len; mi = in_match_int; me = in_match_ext;
        pr = cfg_promisc;    de = cfg_dup_en;
        fc = fbuf[0];
        hl = int'(h);
        r  = exp_route(fc, m, mi, me, pr);
        mac  = (fc[5:4] == 2'b00) && (fc[3:0] != 4'd0) && fc[7];
        span = fc[6] ? 12 : 4;
        klen = 0;
        for (int i = 0; i < flen; i++) begin
            if (i == 0 || i > span) begin
                key[klen] = fbuf[i];
                klen++;
            end
        end
        dup = de && mac && (r >= 0) && last_ok && (klen == last_klen);
        if (dup) begin
            for (int i = 0; i < klen; i++) if (key[i] != last_key[i]) dup = 1'b0;
        end
        if (mac && r >= 0 && !dup) begin
            for (int i = 0; i < klen; i++) last_key[i] = key[i];
            last_klen = klen;
            last_ok   = 1'b1;
        end
        if (r == -1)      tag = (fc[5:0] == 6'd0) ? "R3" : "R8";
        else if (r == 3)  tag = "R4";
        else if (r == 2)  tag = "R6";
        else if (r == 0)  tag = m ? "R5" : "R7";
        else              tag = (!mi && pr) ? "R8" : "R7";
        for (int i = 0; i < flen; i++) begin
            logic [1:0] ec;
            logic       es, ee;
            if (scramble && i == 1) begin
                cfg_split_mode = ~m; cfg_hdr_len = ~h; in_match_int = ~mi;
                in_match_ext = ~me;  cfg_promisc = ~pr; cfg_dup_en = ~de;
            end
            drive_byte(1'b1, i == 0, i == flen - 1, fbuf[i]);
            if (r == 3) begin
                ec = (i < hl) ? 2'd1 : 2'd2;
                es = (i == 0 && hl > 0) || (i == hl);
                ee = (i == flen - 1) || (i < hl && i == hl - 1);
            end else begin
                ec = (r < 0) ? 2'd0 : 2'(r);
                es = (i == 0);
                ee = (i == flen - 1);
            end
            check($sformatf("%s %s R9 R2 frame fc=%h byte %0d", ctx, tag, fc, i),
                  r >= 0, ec, es, ee, dup && (i == flen - 1), fbuf[i]);
        end
        cfg_split_mode = m; cfg_hdr_len = h; in_match_int = mi;
        in_match_ext = me;  cfg_promisc = pr; cfg_dup_en = de;
        drive_byte(1'b0, 1'b0, 1'b0, 8'h00);
    endtask

    task automatic fill(input logic [7:0] fc, input int len, input int seed);
        flen    = len;
        fbuf[0] = fc;
        for (int i = 1; i < len; i++) fbuf[i] = 8'(i * 37 + seed);
    endtask

    initial begin
        logic [7:0] fcs [0:5];
        int         hls [0:2];
        int         lens [0:2];
        fcs[0] = 8'h00; fcs[1] = 8'h40; fcs[2] = 8'h41;
        fcs[3] = 8'hC2; fcs[4] = 8'h50; fcs[5] = 8'h20;
        hls[0] = 0; hls[1] = 3; hls[2] = 5;
        lens[0] = 1; lens[1] = 4; lens[2] = 9;

        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check("R1 reset", 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        drive_byte(1'b0, 1'b0, 1'b0, 8'h00);
        check("R1 after release", 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 8'h00);

        // Sweep: frame types, matches, promiscuity, modes, header lengths, lengths.
        // Duplicate cancelling off throughout, so no abort may appear (R11).
        for (int f = 0; f < 6; f++)
            for (int mt = 0; mt < 4; mt++)
                for (int p = 0; p < 2; p++)
                    for (int md = 0; md < 2; md++)
                        for (int hx = 0; hx < 3; hx++)
                            for (int lx = 0; lx < 3; lx++) begin
                                cfg_split_mode = md[0];
                                cfg_hdr_len    = HLEN_W'(hls[hx]);
                                cfg_promisc    = p[0];
                                cfg_dup_en     = 1'b0;
                                in_match_int   = mt[0];
                                in_match_ext   = mt[1];
                                fill(fcs[f], lens[lx], f * 11 + lx);
                                run_frame("sweep R11", 1'b0);
                            end

        // R12: configuration and match flags changed after the start byte
        cfg_split_mode = 1'b1; cfg_hdr_len = 6'd2; cfg_promisc = 1'b0;
        in_match_int = 1'b1; in_match_ext = 1'b0; cfg_dup_en = 1'b0;
        fill(8'h50, 7, 3);
        run_frame("R12 late cfg", 1'b1);
        cfg_split_mode = 1'b0;
        fill(8'h41, 5, 9);
        run_frame("R12 late cfg", 1'b1);

        // R12: stray bytes outside any frame
        for (int i = 0; i < 3; i++) begin
            drive_byte(1'b1, 1'b0, i == 2, 8'(8'hA0 + i));
            check("R12 stray byte", 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 8'h00);
        end
        drive_byte(1'b0, 1'b0, 1'b0, 8'h00);

        // R10 / R11: duplicate cancelling, address-sort mode, internal match
        cfg_split_mode = 1'b0; cfg_promisc = 1'b0; cfg_dup_en = 1'b1;
        in_match_int = 1'b1; in_match_ext = 1'b0;
        fill(8'hC2, 16, 5);
        run_frame("R10 first", 1'b0);
        run_frame("R10 repeat", 1'b0);
        for (int i = 1; i <= 12; i++) fbuf[i] = 8'(i * 5);
        run_frame("R10 other addresses", 1'b0);
        fbuf[15] = 8'h3C;
        run_frame("R10 new info", 1'b0);
        begin
            logic [7:0] keep [0:31];
            int         keep_len;
            keep_len = flen;
            for (int i = 0; i < 32; i++) keep[i] = fbuf[i];
            fill(8'h50, 16, 5);
            run_frame("R11 data frame", 1'b0);
            run_frame("R11 data frame repeat", 1'b0);
            flen = keep_len;
            for (int i = 0; i < 32; i++) fbuf[i] = keep[i];
        end
        run_frame("R10 after data frames", 1'b0);
        cfg_dup_en = 1'b0;
        run_frame("R11 cancelling off", 1'b0);
        cfg_dup_en = 1'b1;
        fill(8'h82, 8, 21);
        run_frame("R10 short first", 1'b0);
        run_frame("R10 short repeat", 1'b0);
        in_match_int = 1'b0;
        fill(8'h82, 8, 40);
        run_frame("R10 dropped frame", 1'b0);
        in_match_int = 1'b1;
        fill(8'h82, 8, 21);
        run_frame("R10 after dropped", 1'b0);
        in_match_ext = 1'b1;
        run_frame("R10 external repeat", 1'b0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule